// File: doc/BRIEF.md
# Receive Ring Record Packer

This block sits between a serial receiver and a memory ring. Every received character, and every enabled change on the carrier-detect or clear-to-send line, is posted as one byte slot: a data byte paired with a status byte. Four slots make one 8-byte ring entry. The data bytes fill the low half of the entry in arrival order, and the matching status bytes fill the high half. A completed entry is issued as a single write request at the producer pointer. The producer pointer then moves on by one entry and wraps within a 1 KB or a 4 KB ring.

Software owns the consumer pointer. Each time software writes it, software may also arm a timeout counter that steps on a 16 kHz tick. When the counter runs out, it raises a one-cycle event and pushes out any partly filled entry. A drain request does the same flush on demand. The block compares the number of occupied entries with a threshold and drives a high-water level. It refuses new slots while the ring is full, and it reports the lost characters through an overrun flag on the next byte it accepts.

Top module: `rxr_record_packer`

## Requirements
- R1: Status byte layout: bit7 data-valid, bit6 modem-valid, bit5 DCD level, bit4 CTS level, bit3 break, bit2 framing error, bit1 parity error, bit0 overrun. The break, framing and parity bits, and the data byte itself, are zero unless data-valid is set. The DCD, CTS and overrun bits are zero unless modem-valid is set.
- R2: A write request carries data byte k at wr_data_o[8k+7:8k] and its status byte at wr_data_o[32+8k+7:32+8k], with slot 0 being the oldest byte. wr_addr_o is the producer pointer the entry was written at. wr_valid_o is high for one cycle, in the cycle after the byte or flush that completed the entry.
- R3: The producer pointer is a byte address that starts at 0 and advances by 8 for each write. It wraps with mask 0xFF8 when cfg_ring_4k_i=1 and with mask 0x3F8 when cfg_ring_4k_i=0. A consumer pointer written through cons_ptr_i is masked the same way.
- R4: The ring is full when (producer+8) masked equals the consumer. While the ring is full, no slot is accepted and no write is issued. The first byte accepted afterwards has both overrun and modem-valid set.
- R5: hiwat_o is 1 exactly when the occupied entry count ((producer-consumer) masked, divided by 8) is greater than the 9-bit cfg_hiwat_thr_i.
- R6: A change on dcd_i with cfg_post_dcd_i=1, or a change on cts_i with cfg_post_cts_i=1, posts a slot with modem-valid set and data-valid clear. A change on a line whose enable is 0 posts nothing.
- R7: A consumer write with cons_arm_i=1 arms the timer and loads the reload value, which timer_count_o then shows. Each tick_16k_i while armed lowers the count by one. The tick that finds a count of 1 or less disarms the timer, sets the count to 0 and raises timer_evt_o for one cycle. Ticks have no effect while the timer is disarmed.
- R8: A timer expiry flushes a partly filled entry. Slots that hold no byte carry a zero data byte and a zero status byte.
- R9: drain_i flushes a partly filled entry in the same way. With no slot filled, drain_i issues no write and leaves the producer pointer unchanged.
- R10: After reset wr_valid_o, hiwat_o and timer_evt_o are 0, and prod_ptr_o and timer_count_o are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid_i | input | 1 | A received character is present this cycle |
| rx_data_i | input | 8 | Received character |
| rx_par_err_i | input | 1 | Parity error for the character |
| rx_frm_err_i | input | 1 | Framing error for the character |
| rx_brk_i | input | 1 | Character is a break |
| cts_i | input | 1 | Clear-to-send line level |
| dcd_i | input | 1 | Carrier-detect line level |
| cfg_ring_4k_i | input | 1 | 1 selects a 4 KB ring, 0 a 1 KB ring |
| cfg_hiwat_thr_i | input | 9 | High-water entry threshold |
| cfg_post_dcd_i | input | 1 | Post a slot on a carrier-detect change |
| cfg_post_cts_i | input | 1 | Post a slot on a clear-to-send change |
| cfg_tmr_reload_i | input | 12 | Timeout reload value in ticks |
| cons_we_i | input | 1 | Consumer pointer write strobe |
| cons_ptr_i | input | 12 | Consumer pointer byte address |
| cons_arm_i | input | 1 | Arm the timer along with the consumer write |
| drain_i | input | 1 | Flush a partly filled entry |
| tick_16k_i | input | 1 | One-cycle strobe at 16 kHz |
| wr_valid_o | output | 1 | Ring write request |
| wr_addr_o | output | 12 | Ring byte address of the entry |
| wr_data_o | output | 64 | Entry: data bytes low, status bytes high |
| prod_ptr_o | output | 12 | Producer pointer |
| hiwat_o | output | 1 | Occupancy above threshold |
| timer_evt_o | output | 1 | Timer expiry pulse |
| timer_count_o | output | 12 | Current timer count |

## Verification
On every cycle, the assertions check several invariants. No write is issued while the ring is full, and every written entry has a valid first slot. The write address always trails the updated producer pointer. The producer pointer holds still when no entry is pushed. A full ring reads its maximum occupancy. The timer count steps down by one per tick, and its expiry pulse lasts one cycle and disarms the timer. Other behaviour can only be shown by the bench scenarios, which compare each entry against a model in the bench: the byte order and status layout, zero-filled unused slots, overrun reporting once space returns, ignored line changes when posting is disabled, the wrap in the 1 KB ring, and the high-water level under random pointer movement.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int RING_PTR_W  = 12;
  localparam int SMALL_PTR_W = 10;
  localparam int ENTRY_BYTES = 8;
  localparam int ENTRY_LSB   = 3;
  localparam int OCC_W       = RING_PTR_W - ENTRY_LSB;

  typedef logic [RING_PTR_W-1:0] rptr_t;
  typedef logic [OCC_W-1:0]      occ_t;

  // status byte bit positions (decoded by software)
  localparam int ST_OVR = 0;
  localparam int ST_PAR = 1;
  localparam int ST_FRM = 2;
  localparam int ST_BRK = 3;
  localparam int ST_CTS = 4;
  localparam int ST_DCD = 5;
  localparam int ST_MV  = 6;
  localparam int ST_DV  = 7;

  function automatic rptr_t ring_mask(input logic big);
    rptr_t wide_m, small_m;
    wide_m = '1;
    wide_m[ENTRY_LSB-1:0] = '0;
    small_m = wide_m;
    small_m[RING_PTR_W-1:SMALL_PTR_W] = '0;
    return big ? wide_m : small_m;
  endfunction

  function automatic rptr_t ring_advance(input rptr_t p, input rptr_t m);
    return (p + rptr_t'(ENTRY_BYTES)) & m;
  endfunction

  function automatic occ_t ring_used(input rptr_t p, input rptr_t c, input rptr_t m);
    rptr_t d;
    d = (p - c) & m;
    return d[RING_PTR_W-1:ENTRY_LSB];
  endfunction

  function automatic logic [7:0] make_status(input logic dv, input logic mv,
      input logic ovr, input logic par, input logic frm, input logic brk,
      input logic cts, input logic dcd);
    logic [7:0] s;
    s = '0;
    s[ST_DV]  = dv;
    s[ST_MV]  = mv;
    s[ST_PAR] = dv & par;
    s[ST_FRM] = dv & frm;
    s[ST_BRK] = dv & brk;
    s[ST_CTS] = mv & cts;
    s[ST_DCD] = mv & dcd;
    s[ST_OVR] = mv & ovr;
    return s;
  endfunction
endpackage

// File: rtl/rxr_slot_packer.sv
module rxr_slot_packer
  import rxr_pkg::*;
#(
  parameter int SLOTS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 post_i,
  input  logic                 dv_i,
  input  logic                 modem_i,
  input  logic [7:0]           data_i,
  input  logic                 par_i,
  input  logic                 frm_i,
  input  logic                 brk_i,
  input  logic                 cts_i,
  input  logic                 dcd_i,
  input  logic                 flush_i,
  input  logic                 full_i,
  output logic                 push_o,
  output logic                 wr_valid_o,
  output logic [SLOTS*16-1:0]  wr_data_o
);
  localparam int FILL_W = $clog2(SLOTS) + 1;

  logic [7:0]        dat_q [SLOTS];
  logic [7:0]        sts_q [SLOTS];
  logic [7:0]        dat_n [SLOTS];
  logic [7:0]        sts_n [SLOTS];
  logic [FILL_W-1:0] fill_q, fill_n;
  logic              ovr_q;
  logic              accept_w;
  logic [7:0]        stat_w;
  logic [7:0]        byte_w;
  logic [SLOTS*16-1:0] rec_w;

  assign accept_w = post_i && !full_i;
  assign stat_w   = make_status(dv_i, modem_i | ovr_q, ovr_q, par_i, frm_i,
                                brk_i, cts_i, dcd_i);
  assign byte_w   = dv_i ? data_i : 8'h00;

  always_comb begin
    fill_n = fill_q + FILL_W'(accept_w);
    for (int k = 0; k < SLOTS; k++) begin
      dat_n[k] = dat_q[k];
      sts_n[k] = sts_q[k];
      if (accept_w && fill_q == FILL_W'(k)) begin
        dat_n[k] = byte_w;
        sts_n[k] = stat_w;
      end
    end
  end

  always_comb begin
    for (int k = 0; k < SLOTS; k++) begin
      rec_w[8*k +: 8]           = dat_n[k];
      rec_w[8*SLOTS + 8*k +: 8] = sts_n[k];
    end
  end

  assign push_o = !full_i &&
                  ((fill_n == FILL_W'(SLOTS)) || (flush_i && fill_n != '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      fill_q     <= '0;
      ovr_q      <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_data_o  <= '0;
      for (int k = 0; k < SLOTS; k++) begin
        dat_q[k] <= '0;
        sts_q[k] <= '0;
      end
    end else begin
      wr_valid_o <= push_o;
      if (push_o) begin
        wr_data_o <= rec_w;
        fill_q    <= '0;
        for (int k = 0; k < SLOTS; k++) begin
          dat_q[k] <= '0;
          sts_q[k] <= '0;
        end
      end else begin
        fill_q <= fill_n;
        for (int k = 0; k < SLOTS; k++) begin
          dat_q[k] <= dat_n[k];
          sts_q[k] <= sts_n[k];
        end
      end
      if (post_i && full_i)
        ovr_q <= 1'b1;
      else if (accept_w)
        ovr_q <= 1'b0;
    end
  end

  // R4: nothing is pushed into a full ring
  p_no_push_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    push_o |-> !full_i);
  // R2: the oldest slot of every written entry carries a valid flag
  p_first_slot_valid_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> (wr_data_o[8*SLOTS+ST_DV] || wr_data_o[8*SLOTS+ST_MV]));
endmodule

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr
  import rxr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   big_i,
  input  logic   push_i,
  input  logic   cons_we_i,
  input  rptr_t  cons_i,
  input  occ_t   thresh_i,
  output rptr_t  prod_o,
  output logic   full_o,
  output logic   hiwat_o
);
  rptr_t mask_w;
  rptr_t prod_q, cons_q;
  occ_t  used_w;

  assign mask_w  = ring_mask(big_i);
  assign used_w  = ring_used(prod_q, cons_q, mask_w);
  assign full_o  = ring_advance(prod_q, mask_w) == cons_q;
  assign hiwat_o = used_w > thresh_i;
  assign prod_o  = prod_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (push_i)
        prod_q <= ring_advance(prod_q, mask_w);
      if (cons_we_i)
        cons_q <= cons_i & mask_w;
    end
  end

  // R3: the producer only moves when an entry is pushed
  p_prod_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !push_i |=> $stable(prod_q));
  // R4: a full ring shows its largest possible occupancy
  p_full_depth_r4: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> used_w == mask_w[RING_PTR_W-1:ENTRY_LSB]);
endmodule

// File: rtl/rxr_flush_timer.sv
module rxr_flush_timer #(
  parameter int CNT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick_i,
  input  logic             arm_i,
  input  logic [CNT_W-1:0] reload_i,
  output logic             expire_o,
  output logic             evt_o,
  output logic [CNT_W-1:0] count_o
);
  logic             armed_q;
  logic [CNT_W-1:0] count_q;

  assign expire_o = armed_q && tick_i && !arm_i && (count_q <= CNT_W'(1));
  assign count_o  = count_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b0;
      count_q <= '0;
      evt_o   <= 1'b0;
    end else begin
      evt_o <= expire_o;
      if (arm_i) begin
        armed_q <= 1'b1;
        count_q <= reload_i;
      end else if (expire_o) begin
        armed_q <= 1'b0;
        count_q <= '0;
      end else if (armed_q && tick_i) begin
        count_q <= count_q - 1'b1;
      end
    end
  end

  // R7: expiry event is a single-cycle pulse
  p_evt_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |=> !evt_o);
  // R7: expiry leaves the timer disarmed
  p_evt_disarm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    evt_o |-> !armed_q);
  // R7: a non-final tick lowers the count by one
  p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (armed_q && tick_i && !arm_i && count_q > CNT_W'(1)) |=>
      count_q == $past(count_q) - 1'b1);
endmodule

// File: rtl/rxr_record_packer.sv
module rxr_record_packer
  import rxr_pkg::*;
#(
  parameter int SLOTS = 4,
  parameter int TMR_W = 12
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 rx_valid_i,
  input  logic [7:0]           rx_data_i,
  input  logic                 rx_par_err_i,
  input  logic                 rx_frm_err_i,
  input  logic                 rx_brk_i,
  input  logic                 cts_i,
  input  logic                 dcd_i,
  input  logic                 cfg_ring_4k_i,
  input  logic [OCC_W-1:0]     cfg_hiwat_thr_i,
  input  logic                 cfg_post_dcd_i,
  input  logic                 cfg_post_cts_i,
  input  logic [TMR_W-1:0]     cfg_tmr_reload_i,
  input  logic                 cons_we_i,
  input  logic [RING_PTR_W-1:0] cons_ptr_i,
  input  logic                 cons_arm_i,
  input  logic                 drain_i,
  input  logic                 tick_16k_i,
  output logic                 wr_valid_o,
  output logic [RING_PTR_W-1:0] wr_addr_o,
  output logic [SLOTS*16-1:0]  wr_data_o,
  output logic [RING_PTR_W-1:0] prod_ptr_o,
  output logic                 hiwat_o,
  output logic                 timer_evt_o,
  output logic [TMR_W-1:0]     timer_count_o
);
  logic  cts_q, dcd_q;
  logic  modem_evt_w, post_w, flush_w, push_w, full_w, expire_w;
  rptr_t prod_w;

  assign modem_evt_w = (cfg_post_dcd_i && (dcd_i != dcd_q)) ||
                       (cfg_post_cts_i && (cts_i != cts_q));
  assign post_w      = rx_valid_i || modem_evt_w;
  assign flush_w     = drain_i || expire_w;
  assign prod_ptr_o  = prod_w;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cts_q     <= 1'b0;
      dcd_q     <= 1'b0;
      wr_addr_o <= '0;
    end else begin
      cts_q <= cts_i;
      dcd_q <= dcd_i;
      if (push_w)
        wr_addr_o <= prod_w;
    end
  end

  rxr_slot_packer #(.SLOTS(SLOTS)) u_pack (
    .clk        (clk),
    .rst_n      (rst_n),
    .post_i     (post_w),
    .dv_i       (rx_valid_i),
    .modem_i    (modem_evt_w),
    .data_i     (rx_data_i),
    .par_i      (rx_par_err_i),
    .frm_i      (rx_frm_err_i),
    .brk_i      (rx_brk_i),
    .cts_i      (cts_i),
    .dcd_i      (dcd_i),
    .flush_i    (flush_w),
    .full_i     (full_w),
    .push_o     (push_w),
    .wr_valid_o (wr_valid_o),
    .wr_data_o  (wr_data_o)
  );

  rxr_ring_ptr u_ptr (
    .clk       (clk),
    .rst_n     (rst_n),
    .big_i     (cfg_ring_4k_i),
    .push_i    (push_w),
    .cons_we_i (cons_we_i),
    .cons_i    (cons_ptr_i),
    .thresh_i  (cfg_hiwat_thr_i),
    .prod_o    (prod_w),
    .full_o    (full_w),
    .hiwat_o   (hiwat_o)
  );

  rxr_flush_timer #(.CNT_W(TMR_W)) u_tmr (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick_i   (tick_16k_i),
    .arm_i    (cons_we_i && cons_arm_i),
    .reload_i (cfg_tmr_reload_i),
    .expire_o (expire_w),
    .evt_o    (timer_evt_o),
    .count_o  (timer_count_o)
  );

  // R2: a written entry sits behind the already advanced producer
  p_addr_trails_prod_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid_o |-> wr_addr_o != prod_ptr_o);
  // R8: the expiry pulse and the flushed write land in the same cycle
  p_expire_flush_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (expire_w && !full_w && !post_w) |=> timer_evt_o);
endmodule

// File: tb/rxr_record_packer_tb_top.sv
module rxr_record_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        rx_valid_i = 0, rx_par_err_i = 0, rx_frm_err_i = 0, rx_brk_i = 0;
  logic [7:0]  rx_data_i = 0;
  logic        cts_i = 0, dcd_i = 0, cfg_ring_4k_i = 1;
  logic [8:0]  cfg_hiwat_thr_i = 9'd5;
  logic        cfg_post_dcd_i = 0, cfg_post_cts_i = 0;
  logic [11:0] cfg_tmr_reload_i = 12'd3;
  logic        cons_we_i = 0, cons_arm_i = 0, drain_i = 0, tick_16k_i = 0;
  logic [11:0] cons_ptr_i = 0;
  logic        wr_valid_o, hiwat_o, timer_evt_o;
  logic [11:0] wr_addr_o, prod_ptr_o, timer_count_o;
  logic [63:0] wr_data_o;

  always #4 clk = ~clk;

  rxr_record_packer dut_i (.*);

  int n_chk = 0, n_err = 0;
  string cur_req = "R2";
  int m_prod, m_cons, m_mask, m_fill, m_tcnt;
  bit m_ovr, m_armed;
  logic m_cts, m_dcd;
  logic [7:0] m_dat [4];
  logic [7:0] m_sts [4];
  logic [75:0] exp_q [$];

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_status(input bit dv, input bit mv, input bit ov,
      input bit p, input bit f, input bit b, input logic c, input logic d);
    return {dv, mv, mv & d, mv & c, dv & b, dv & f, dv & p, mv & ov};
  endfunction

  function automatic bit m_full();
    return ((m_prod + 8) & m_mask) == m_cons;
  endfunction

  function automatic bit exp_hiwat();
    return (((m_prod - m_cons) & m_mask) >> 3) > int'(cfg_hiwat_thr_i);
  endfunction

  task automatic m_flush();
    logic [63:0] rec;
    if (m_fill == 0 || m_full()) return;
    for (int k = 0; k < 4; k++) begin
      rec[8*k +: 8]      = m_dat[k];
      rec[32 + 8*k +: 8] = m_sts[k];
      m_dat[k] = 0;
      m_sts[k] = 0;
    end
    exp_q.push_back({m_prod[11:0], rec});
    m_prod = (m_prod + 8) & m_mask;
    m_fill = 0;
  endtask

  task automatic m_post(input bit dv, input logic [7:0] d, input bit p,
                        input bit f, input bit b, input bit mv);
    if (m_full()) begin
      m_ovr = 1;
      return;
    end
    m_dat[m_fill] = dv ? d : 8'h00;
    m_sts[m_fill] = exp_status(dv, mv | m_ovr, m_ovr, p, f, b, m_cts, m_dcd);
    m_ovr = 0;
    m_fill++;
    if (m_fill == 4) m_flush();
  endtask

  always @(negedge clk) begin
    if (rst_n && wr_valid_o) begin
      if (exp_q.size() == 0) begin
        check(cur_req, "unexpected write", {52'd0, wr_addr_o}, 64'hFFFF);
      end else begin
        logic [75:0] e;
        e = exp_q.pop_front();
        check(cur_req, "write address", {52'd0, wr_addr_o}, {52'd0, e[75:64]});
        check(cur_req, "entry contents", wr_data_o, e[63:0]);
      end
    end
  end

  task automatic do_reset(input bit big);
    @(negedge clk);
    rst_n = 0;
    cfg_ring_4k_i = big;
    cts_i = 0; dcd_i = 0;
    m_prod = 0; m_cons = 0; m_fill = 0; m_ovr = 0; m_armed = 0; m_tcnt = 0;
    m_cts = 0; m_dcd = 0;
    m_mask = big ? 'hFF8 : 'h3F8;
    for (int k = 0; k < 4; k++) begin m_dat[k] = 0; m_sts[k] = 0; end
    exp_q.delete();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send_char(input logic [7:0] d, input bit p, input bit f, input bit b);
    m_post(1, d, p, f, b, 0);
    rx_valid_i = 1; rx_data_i = d; rx_par_err_i = p; rx_frm_err_i = f; rx_brk_i = b;
    @(negedge clk);
    rx_valid_i = 0; rx_par_err_i = 0; rx_frm_err_i = 0; rx_brk_i = 0;
  endtask

  task automatic set_lines(input logic c, input logic d);
    bit evt;
    evt = (cfg_post_cts_i && c != m_cts) || (cfg_post_dcd_i && d != m_dcd);
    m_cts = c; m_dcd = d;
    if (evt) m_post(0, 0, 0, 0, 0, 1);
    cts_i = c; dcd_i = d;
    @(negedge clk);
  endtask

  task automatic do_drain();
    m_flush();
    drain_i = 1;
    @(negedge clk);
    drain_i = 0;
  endtask

  task automatic write_cons(input int ptr, input bit arm);
    m_cons = ptr & m_mask;
    if (arm) begin m_armed = 1; m_tcnt = cfg_tmr_reload_i; end
    cons_we_i = 1; cons_ptr_i = ptr[11:0]; cons_arm_i = arm;
    @(negedge clk);
    cons_we_i = 0; cons_arm_i = 0;
  endtask

  task automatic do_tick(input string req);
    bit exp_evt;
    exp_evt = 0;
    if (m_armed) begin
      if (m_tcnt <= 1) begin
        exp_evt = 1; m_flush(); m_armed = 0; m_tcnt = 0;
      end else m_tcnt--;
    end
    tick_16k_i = 1;
    @(negedge clk);
    tick_16k_i = 0;
    check(req, "timer event", {63'd0, timer_evt_o}, {63'd0, exp_evt});
    check(req, "timer count", {52'd0, timer_count_o}, 64'(m_tcnt));
  endtask

  initial begin
    #(8 * 200000);
    check("WATCHDOG", "run timed out", 64'd1, 64'd0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd2417));
    do_reset(1);
    // R10: reset state
    check("R10", "wr_valid", {63'd0, wr_valid_o}, 64'd0);
    check("R10", "prod_ptr", {52'd0, prod_ptr_o}, 64'd0);
    check("R10", "hiwat", {63'd0, hiwat_o}, 64'd0);
    check("R10", "timer_evt", {63'd0, timer_evt_o}, 64'd0);
    check("R10", "timer_count", {52'd0, timer_count_o}, 64'd0);

    // R1 and R2: one entry of chars with assorted error flags
    cur_req = "R1";
    send_char(8'hA5, 0, 0, 0);
    send_char(8'h3C, 1, 0, 0);
    send_char(8'h7E, 0, 1, 1);
    send_char(8'h00, 0, 0, 1);
    @(negedge clk);
    check("R3", "producer after one entry", {52'd0, prod_ptr_o}, 64'd8);

    // R9: drain of a partial entry, then drain with nothing held
    cur_req = "R9";
    send_char(8'h11, 0, 0, 0);
    send_char(8'h22, 1, 1, 0);
    do_drain();
    @(negedge clk);
    do_drain();
    @(negedge clk);
    check("R9", "producer after empty drain", {52'd0, prod_ptr_o}, 64'd16);

    // R6: line changes posted only when enabled
    cur_req = "R6";
    cfg_post_dcd_i = 1; cfg_post_cts_i = 0;
    @(negedge clk);
    set_lines(0, 1);
    set_lines(1, 1);
    do_drain();
    @(negedge clk);
    check("R6", "producer after dcd post", {52'd0, prod_ptr_o}, 64'd24);
    cfg_post_cts_i = 1;
    @(negedge clk);
    set_lines(0, 1);
    send_char(8'h5A, 0, 0, 0);
    do_drain();
    @(negedge clk);
    cfg_post_dcd_i = 0; cfg_post_cts_i = 0;

    // R7 and R8: armed timer flushes a partial entry
    cur_req = "R8";
    send_char(8'hC3, 0, 0, 0);
    write_cons(m_cons, 1);
    check("R7", "count after arm", {52'd0, timer_count_o}, 64'd3);
    do_tick("R7");
    do_tick("R7");
    do_tick("R8");
    do_tick("R7");
    cfg_tmr_reload_i = 12'd0;
    write_cons(m_cons, 1);
    do_tick("R7");
    cfg_tmr_reload_i = 12'd3;
    @(negedge clk);
    check("R8", "producer after timer flush", {52'd0, prod_ptr_o}, 64'(m_prod));

    // R5 and R2: random traffic with moving consumer
    cur_req = "R2";
    for (int i = 0; i < 300; i++) begin
      int r;
      r = $urandom_range(0, 19);
      send_char(8'($urandom), ($urandom_range(0, 3) == 0), ($urandom_range(0, 5) == 0),
                ($urandom_range(0, 7) == 0));
      if (r == 0) write_cons(m_prod, 0);
      else if (r == 1) do_drain();
      check("R5", "high-water level", {63'd0, hiwat_o}, {63'd0, exp_hiwat()});
      check("R3", "producer pointer", {52'd0, prod_ptr_o}, 64'(m_prod));
    end
    write_cons(m_prod, 0);
    check("R5", "high-water after release", {63'd0, hiwat_o}, 64'd0);

    // R4 and R3: 1 KB ring filled to full, overrun, then wrap
    do_reset(0);
    cur_req = "R4";
    for (int i = 0; i < 127 * 4; i++) send_char(8'(i), 0, 0, 0);
    @(negedge clk);
    check("R4", "producer at full", {52'd0, prod_ptr_o}, 64'h3F8);
    check("R5", "high-water at full", {63'd0, hiwat_o}, 64'd1);
    send_char(8'hEE, 0, 0, 0);
    send_char(8'hEF, 0, 0, 0);
    do_drain();
    @(negedge clk);
    check("R4", "producer held while full", {52'd0, prod_ptr_o}, 64'h3F8);
    write_cons(8, 0);
    send_char(8'h81, 0, 0, 0);
    send_char(8'h82, 0, 0, 0);
    send_char(8'h83, 0, 0, 0);
    send_char(8'h84, 0, 0, 0);
    @(negedge clk);
    check("R3", "producer wrap in 1 KB ring", {52'd0, prod_ptr_o}, 64'd0);
    cfg_hiwat_thr_i = 9'd127;
    @(negedge clk);
    check("R5", "occupancy equal to threshold", {63'd0, hiwat_o}, 64'd0);
    repeat (3) @(negedge clk);
    check("R4", "all expected entries written", 64'(exp_q.size()), 64'd0);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule